// File: doc/BRIEF.md
# Inter-Processor Mailbox FIFO

This block carries 32-bit messages in one direction from a sending processor to a receiving processor. The sender pushes words into a small FIFO through a register port, and the receiver takes them out again, either consuming the oldest word or looking at it without consuming it. Each word is passed through unaltered, so a channel number kept in bits 3:0 and a payload kept in bits 31:4 reach the receiver intact. Replies travel on the same channel as the command that caused them.

The register port is a single-cycle valid/write/address/data interface. Read data is registered and appears one clock after the access. A status word reports whether the FIFO is full or empty and how many words it holds. A configuration word holds several things:
- the interrupt enables;
- the pending flags, which can only be read;
- a two-step flush control;
- two sticky error flags, one for a push into a full FIFO and one for a pop from an empty FIFO.

One interrupt line combines the enabled pending conditions.

Top module: `ipc_mailbox`

## Requirements
- R1: A write at offset 0xA0 appends the word to the FIFO. A read at offset 0x80 returns the oldest stored word and removes it. Words come out in arrival order with all 32 bits unchanged.
- R2: A read at offset 0x90 returns the oldest word without removing it, and the count does not change. On an empty FIFO this read returns 0 and sets no error flag.
- R3: A read at offset 0x98 returns bit 31 = full, bit 30 = empty and bits 7:0 = the number of stored words. All other bits read 0.
- R4: A write at 0xA0 while the FIFO holds DEPTH words is dropped. The count and contents stay as they were, and config bit 9 becomes 1.
- R5: A read at 0x80 on an empty FIFO returns 0 and sets config bit 10.
- R6: Config bits 9 and 10 stay set until the next write of any value to offset 0x9C, which clears both.
- R7: Writing config bit 3 as 1 leaves the contents untouched, and bit 3 then reads back as 1. A later config write with bit 3 = 0 empties the FIFO.
- R8: Config bits 2:0 are the writable enables: has-data, has-space, peer. Bits 4, 5 and 6 read as the pending flags: bit 4 = FIFO not empty, bit 5 = FIFO not full, bit 6 = level of the peer_event input. Writing bits 4 to 6 has no effect on them.
- R9: irq is 1 exactly when some pending flag and its matching enable are both 1.
- R10: A read at offset 0x94 returns peer_id in bits 1:0 and 0 in all other bits.
- R11: After reset the FIFO is empty, the enables, flush control and error flags are 0, irq is 0 and read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset inside the register window |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered, valid the cycle after a read |
| peer_id | input | 2 | Identity of the sending side, returned at 0x94 |
| peer_event | input | 1 | Opposite-side interrupt request level |
| irq | output | 1 | Combined interrupt output |

## Verification
The bench builds the block with its defaults: DEPTH = 8 and DW = 32. An eight-entry FIFO becomes full after a few pushes, so the drop of a ninth push, the full bit in the status word, and the has-space flag falling to 0 are all checked on a short run. With 32-bit words, the channel nibble and the payload can both be checked intact after the words pass through the FIFO.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int DEPTH = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [7:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [1:0]    peer_id,
  input  logic          peer_event,
  output logic          irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [7:0] OFS_POP  = 8'h80;
  localparam logic [7:0] OFS_PEEK = 8'h90;
  localparam logic [7:0] OFS_SID  = 8'h94;
  localparam logic [7:0] OFS_STAT = 8'h98;
  localparam logic [7:0] OFS_CFG  = 8'h9C;
  localparam logic [7:0] OFS_PUSH = 8'hA0;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic [2:0]    en;
  logic          clr_arm, err_wfull, err_rempty;
  logic [DW-1:0] rd_mux;

  wire empty   = (count == '0);
  wire full    = (count == CW'(DEPTH));
  wire rd_acc  = bus_valid & ~bus_write;
  wire wr_acc  = bus_valid & bus_write;
  wire push_rq = wr_acc && bus_addr == OFS_PUSH;
  wire pop_rq  = rd_acc && bus_addr == OFS_POP;
  wire cfg_wr  = wr_acc && bus_addr == OFS_CFG;
  wire do_push = push_rq && !full;
  wire do_pop  = pop_rq && !empty;
  wire flush   = cfg_wr && clr_arm && !bus_wdata[3];
  wire [2:0] pend = {peer_event, ~full, ~empty};

  assign irq = |(en & pend);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (do_push) mem[wptr] <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (do_push) begin
      wptr  <= bump(wptr);
      count <= count + 1'b1;
    end else if (do_pop) begin
      rptr  <= bump(rptr);
      count <= count - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en         <= '0;
      clr_arm    <= 1'b0;
      err_wfull  <= 1'b0;
      err_rempty <= 1'b0;
    end else if (cfg_wr) begin
      en         <= bus_wdata[2:0];
      clr_arm    <= bus_wdata[3];
      err_wfull  <= 1'b0;
      err_rempty <= 1'b0;
    end else begin
      if (push_rq && full) err_wfull  <= 1'b1;
      if (pop_rq && empty) err_rempty <= 1'b1;
    end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_POP, OFS_PEEK: rd_mux = empty ? '0 : mem[rptr];
      OFS_SID:  rd_mux[1:0] = peer_id;
      OFS_STAT: begin
        rd_mux[DW-1] = full;
        rd_mux[DW-2] = empty;
        rd_mux[7:0]  = 8'(count);
      end
      OFS_CFG: begin
        rd_mux[2:0] = en;
        rd_mux[3]   = clr_arm;
        rd_mux[6:4] = pend;
        rd_mux[9]   = err_wfull;
        rd_mux[10]  = err_rempty;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_mux;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3
  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && bus_addr == OFS_PEEK) |=> $stable(count)); // R2
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_rq && full) |=> (count == $past(count) && err_wfull)); // R4
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_rq && empty) |=> (bus_rdata == '0 && err_rempty)); // R5
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!err_wfull && !err_rempty)); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && clr_arm && !bus_wdata[3]) |=> (count == '0)); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 3'b000) |-> !irq); // R9
endmodule

// File: tb/sim_ipc_mailbox.sv
module sim_ipc_mailbox;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [1:0] peer_id = 2'b00;
  logic peer_event = 0, irq;
  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  logic [31:0] v;

  always #2.5 clk = ~clk;

  ipc_mailbox u0 (.clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_wdata,
                  .bus_rdata, .peer_id, .peer_event, .irq);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    acc(0, a, 0);
    d = bus_rdata;
  endtask

  task automatic push(input logic [31:0] d);
    acc(1, 8'hA0, d);
    if (exp_q.size() < 8) exp_q.push_back(d);
  endtask

  task automatic pop_check(input string tag);
    logic [31:0] e;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'h0;
    rd(8'h80, v);
    chk(tag, v, e);
  endtask

  function automatic logic [31:0] stat_word();
    return {exp_q.size() == 8, exp_q.size() == 0, 22'h0, 8'(exp_q.size())};
  endfunction

  function automatic logic [31:0] cfg_word(input logic [2:0] e, input logic c,
                                           input logic we, input logic re);
    logic [31:0] r = '0;
    r[2:0] = e; r[3] = c;
    r[4] = exp_q.size() != 0; r[5] = exp_q.size() != 8; r[6] = peer_event;
    r[9] = we; r[10] = re;
    return r;
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R11 irq", {31'h0, irq}, 32'h0);
    chk("R11 rdata", bus_rdata, 32'h0);
    rd(8'h98, v); chk("R11 R3 status", v, 32'h4000_0000);
    rd(8'h9C, v); chk("R11 cfg", v, cfg_word(3'b000, 0, 0, 0));

    push(32'hABCD_1231); push(32'h0000_0012); push(32'hFFFF_FFF3);
    rd(8'h98, v); chk("R3 count3", v, stat_word());
    rd(8'h90, v); chk("R2 peek", v, 32'hABCD_1231);
    rd(8'h90, v); chk("R2 peek again", v, 32'hABCD_1231);
    rd(8'h98, v); chk("R2 count kept", v, 32'h0000_0003);
    pop_check("R1 pop0"); pop_check("R1 pop1"); pop_check("R1 pop2");
    pop_check("R5 empty pop");
    rd(8'h9C, v); chk("R5 err bit10", v, cfg_word(3'b000, 0, 0, 1));
    rd(8'h90, v); chk("R2 empty peek", v, 32'h0);
    rd(8'h9C, v); chk("R2 R6 no flag, sticky", v, cfg_word(3'b000, 0, 0, 1));
    acc(1, 8'h9C, 32'h0);
    rd(8'h9C, v); chk("R6 cleared", v, cfg_word(3'b000, 0, 0, 0));

    for (int i = 0; i < 9; i++) push(32'h1000_0000 * i + i);
    rd(8'h98, v); chk("R3 R4 full", v, 32'h8000_0008);
    rd(8'h9C, v); chk("R4 R8 err bit9", v, cfg_word(3'b000, 0, 1, 0));
    for (int i = 0; i < 8; i++) pop_check("R1 R4 drain");
    pop_check("R4 ninth dropped");
    acc(1, 8'h9C, 32'h0);

    push(32'h5555_0005);
    acc(1, 8'h9C, 32'h1);
    chk("R9 has-data irq", {31'h0, irq}, 32'h1);
    acc(1, 8'h9C, 32'h2);
    chk("R9 has-space irq", {31'h0, irq}, 32'h1);
    for (int i = 1; i < 8; i++) push(32'h0000_0100 + i);
    chk("R9 full no irq", {31'h0, irq}, 32'h0);
    acc(1, 8'h9C, 32'h4);
    chk("R9 peer low", {31'h0, irq}, 32'h0);
    peer_event = 1; #1;
    chk("R9 peer high", {31'h0, irq}, 32'h1);
    rd(8'h9C, v); chk("R8 peer pend", v, cfg_word(3'b100, 0, 0, 0));
    peer_event = 0;

    acc(1, 8'h9C, 32'h8);
    rd(8'h98, v); chk("R7 armed keeps", v, 32'h8000_0008);
    rd(8'h9C, v); chk("R7 arm readback", v, cfg_word(3'b000, 1, 0, 0));
    acc(1, 8'h9C, 32'h0);
    exp_q.delete();
    rd(8'h98, v); chk("R7 flushed", v, 32'h4000_0000);
    pop_check("R7 nothing left");

    acc(1, 8'h9C, 32'h0000_0670);
    rd(8'h9C, v); chk("R8 R6 ro bits", v, cfg_word(3'b000, 0, 0, 0));

    peer_id = 2'b10;
    rd(8'h94, v); chk("R10 id2", v, 32'h2);
    peer_id = 2'b01;
    rd(8'h94, v); chk("R10 id1", v, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule